// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the integer register file of a processor core that uses register windows. Software addresses 32 architectural registers with 5-bit indices. Behind them sits a larger physical array: eight globals that every window shares, plus one 16-entry set for each window. A current window pointer selects which set the upper 24 architectural indices reach. Each window's set holds its eight private locals and its eight incoming-argument registers. The eight outgoing-argument registers of a window are borrowed from the neighbouring window's set. A call therefore passes arguments with no copying: the caller's outs become the callee's ins.

The file has two combinational read ports and one clocked write port. A save request moves the pointer one window down and a restore request moves it one window up, both modulo the window count. An invalid-window mask supplied by supervisor logic can veto either move. A vetoed move raises an overflow or underflow flag so that a trap handler elsewhere can spill or fill a window. The number of windows is a parameter from 2 to 32.

Top module: `winreg_file`

## Requirements
- R1: After synchronous reset, the window pointer is 0, both trap flags are low and every architectural index reads 0 on both ports.
- R2: Index 0 always reads 0, and a write to index 0 has no effect, even when a read of index 0 happens in the same cycle.
- R3: Indices 1 to 7 reach the same eight global registers whatever the window pointer holds.
- R4: Indices 16 to 23 (locals) reach storage private to the current window, so a value written in one window is not seen in another and survives a move away and back.
- R5: Indices 8 to 15 (outs) of window w reach the same storage as indices 24 to 31 (ins) of window (w-1) mod NWIN. Out register 8+k therefore reads as in register 24+k after a save.
- R6: A save without trap sets the pointer to (cwp-1) mod NWIN, so 0 wraps to NWIN-1. A restore without trap sets it to (cwp+1) mod NWIN, so NWIN-1 wraps to 0. The pointer always stays below NWIN.
- R7: A save while bit (cwp-1) mod NWIN of the invalid mask is 1 drives overflow_trap high in that same cycle, and the pointer does not change.
- R8: A restore while bit (cwp+1) mod NWIN of the invalid mask is 1 drives underflow_trap high in that same cycle, and the pointer does not change.
- R9: Save and restore requested in the same cycle cancel: no move and no trap flag.
- R10: When a read index equals the write index while a write to a nonzero index is enabled, that read port returns the data being written in the same cycle.
- R11: A write lands at the clock edge in the window that was current during that cycle, even if a save or restore moves the pointer at the same edge. The two read ports work independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Architectural index, read port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Architectural index, read port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural index to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Request to move one window down |
| restore_req | input | 1 | Request to move one window up |
| inv_mask | input | 32 | Invalid-window mask, bit i for window i |
| cwp | output | 5 | Current window pointer |
| overflow_trap | output | 1 | Save vetoed by the mask (same cycle) |
| underflow_trap | output | 1 | Restore vetoed by the mask (same cycle) |

## Verification
The bench builds the file with NWIN set to 5, a count that is not a power of two. This brings the modulo wrap of the pointer in both directions within a few moves, and it checks that the arithmetic does not rely on binary rollover. With five windows, a short run of saves walks the whole ring. That exposes the overlap between the last window and the first, and it places mask bits that sit above the window count on the input, where they must have no effect.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam int ARCH_AW  = 5;
    localparam int WORD_W   = 32;
    localparam int PTR_W    = 5;
    localparam int GLOBALS  = 8;
    localparam int GROUP    = 8;
    localparam int SET_SIZE = 2 * GROUP;

    typedef logic [ARCH_AW-1:0] arch_idx_t;
    typedef logic [PTR_W-1:0]   wptr_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Architectural region decoded from the two top index bits.
    typedef enum logic [1:0] {
        REGION_GLOBAL = 2'd0,
        REGION_OUT    = 2'd1,
        REGION_LOCAL  = 2'd2,
        REGION_IN     = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        MOVE_NONE    = 2'd0,
        MOVE_SAVE    = 2'd1,
        MOVE_RESTORE = 2'd2
    } move_e;

    typedef struct packed {
        logic      en;
        arch_idx_t addr;
        word_t     data;
    } wr_req_t;

    typedef struct packed {
        wptr_t ptr;
        logic  ovf;
        logic  unf;
    } win_stat_t;

    function automatic int phys_count(int nwin);
        return GLOBALS + SET_SIZE * nwin;
    endfunction

    function automatic wptr_t wp_dec(wptr_t p, int nwin);
        return (p == '0) ? wptr_t'(nwin - 1) : p - wptr_t'(1);
    endfunction

    function automatic wptr_t wp_inc(wptr_t p, int nwin);
        return (p == wptr_t'(nwin - 1)) ? '0 : p + wptr_t'(1);
    endfunction

    function automatic region_e region_of(arch_idx_t a);
        return region_e'(a[ARCH_AW-1:ARCH_AW-2]);
    endfunction

endpackage

// File: rtl/winreg_map.sv
// Translates one architectural index into a physical array index.
// Set layout for window w: base = GLOBALS + SET_SIZE*w,
// locals at base+0..7, ins at base+8..15; outs borrow the ins of w-1.
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PAW  = 8
) (
    input  arch_idx_t      arch,
    input  wptr_t          ptr,
    output logic           live,
    output logic [PAW-1:0] idx
);

    wptr_t   below;
    region_e region;
    int      cur_base;
    int      nbr_base;
    int      slot;

    always_comb begin
        below    = wp_dec(ptr, NWIN);
        region   = region_of(arch);
        cur_base = GLOBALS + SET_SIZE * int'(ptr);
        nbr_base = GLOBALS + SET_SIZE * int'(below);
        slot     = int'(arch[2:0]);
        live     = (arch != '0);
        unique case (region)
            REGION_GLOBAL: idx = PAW'(slot);
            REGION_OUT:    idx = PAW'(nbr_base + GROUP + slot);
            REGION_LOCAL:  idx = PAW'(cur_base + slot);
            REGION_IN:     idx = PAW'(cur_base + GROUP + slot);
        endcase
    end

endmodule

// File: rtl/winreg_wctl.sv
// Window pointer with mask-checked save/restore moves.
module winreg_wctl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic [WORD_W-1:0] inv_mask,
    output win_stat_t        stat
);

    wptr_t ptr_q;
    wptr_t ptr_dn;
    wptr_t ptr_up;
    move_e move;
    logic  veto_dn;
    logic  veto_up;

    always_comb begin
        ptr_dn = wp_dec(ptr_q, NWIN);
        ptr_up = wp_inc(ptr_q, NWIN);
        unique case ({save_req, restore_req})
            2'b10:   move = MOVE_SAVE;
            2'b01:   move = MOVE_RESTORE;
            default: move = MOVE_NONE;
        endcase
        veto_dn = (move == MOVE_SAVE)    && inv_mask[ptr_dn];
        veto_up = (move == MOVE_RESTORE) && inv_mask[ptr_up];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (move == MOVE_SAVE && !veto_dn) begin
            ptr_q <= ptr_dn;
        end else if (move == MOVE_RESTORE && !veto_up) begin
            ptr_q <= ptr_up;
        end
    end

    assign stat = '{ptr: ptr_q, ovf: veto_dn, unf: veto_up};

endmodule

// File: rtl/winreg_store.sv
// Physical register array: one write port, NRD combinational read
// ports with write-first forwarding on a physical index match.
module winreg_store
    import winreg_pkg::*;
#(
    parameter int NPHYS = 136,
    parameter int PAW   = 8,
    parameter int NRD   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_live,
    input  logic [PAW-1:0] wr_idx,
    input  word_t          wr_data,
    input  logic           rd_live [NRD],
    input  logic [PAW-1:0] rd_idx  [NRD],
    output word_t          rd_data [NRD]
);

    word_t regs [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_live) begin
            regs[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (!rd_live[g]) begin
                rd_data[g] = '0;
            end else if (wr_live && (wr_idx == rd_idx[g])) begin
                rd_data[g] = wr_data;
            end else begin
                rd_data[g] = regs[rd_idx[g]];
            end
        end
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ARCH_AW-1:0] rd_addr_a,
    output logic [WORD_W-1:0]  rd_data_a,
    input  logic [ARCH_AW-1:0] rd_addr_b,
    output logic [WORD_W-1:0]  rd_data_b,
    input  logic               wr_en,
    input  logic [ARCH_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               save_req,
    input  logic               restore_req,
    input  logic [WORD_W-1:0]  inv_mask,
    output logic [PTR_W-1:0]   cwp,
    output logic               overflow_trap,
    output logic               underflow_trap
);

    localparam int NPHYS = phys_count(NWIN);
    localparam int PAW   = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;
    localparam int WPORT = NRD;

    win_stat_t      stat;
    wr_req_t        wreq;
    arch_idx_t      port_arch [NPORT];
    logic           port_live [NPORT];
    logic [PAW-1:0] port_idx  [NPORT];
    logic           rd_live   [NRD];
    logic [PAW-1:0] rd_idx    [NRD];
    word_t          rd_data   [NRD];

    assign wreq = '{en: wr_en, addr: wr_addr, data: wr_data};

    assign port_arch[0]     = rd_addr_a;
    assign port_arch[1]     = rd_addr_b;
    assign port_arch[WPORT] = wreq.addr;

    winreg_wctl #(.NWIN(NWIN)) u_wctl (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .inv_mask    (inv_mask),
        .stat        (stat)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        winreg_map #(.NWIN(NWIN), .PAW(PAW)) u_map (
            .arch (port_arch[p]),
            .ptr  (stat.ptr),
            .live (port_live[p]),
            .idx  (port_idx[p])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rport
        assign rd_live[r] = port_live[r];
        assign rd_idx[r]  = port_idx[r];
    end

    winreg_store #(.NPHYS(NPHYS), .PAW(PAW), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_live (wreq.en && port_live[WPORT]),
        .wr_idx  (port_idx[WPORT]),
        .wr_data (wreq.data),
        .rd_live (rd_live),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign rd_data_a      = rd_data[0];
    assign rd_data_b      = rd_data[1];
    assign cwp            = stat.ptr;
    assign overflow_trap  = stat.ovf;
    assign underflow_trap = stat.unf;

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
    parameter int NWIN = 8
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_addr_a,
    input logic [31:0] rd_data_a,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        save_req,
    input logic        restore_req,
    input logic [31:0] inv_mask,
    input logic [4:0]  cwp,
    input logic        overflow_trap,
    input logic        underflow_trap
);

    logic [4:0] dn_w;
    logic [4:0] up_w;

    assign dn_w = (cwp == 5'd0) ? 5'(NWIN - 1) : cwp - 5'd1;
    assign up_w = (cwp == 5'(NWIN - 1)) ? 5'd0 : cwp + 5'd1;

    // R6
    cwp_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cwp) < NWIN);

    // R6
    save_step_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && !restore_req && !overflow_trap) |=> (cwp == $past(dn_w)));

    // R6
    restore_step_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !underflow_trap) |=> (cwp == $past(up_w)));

    // R7
    overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_trap |=> $stable(cwp));

    // R7
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_trap |-> (save_req && !restore_req && inv_mask[dn_w]));

    // R8
    underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_trap |=> $stable(cwp));

    // R8
    underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_trap |-> (restore_req && !save_req && inv_mask[up_w]));

    // R9
    both_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |-> (!overflow_trap && !underflow_trap));

    // R9
    both_still_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |=> $stable(cwp));

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == 5'd0) |-> (rd_data_a == 32'd0));

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 5'd0 && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rd_addr_a      (rd_addr_a),
    .rd_data_a      (rd_data_a),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .save_req       (save_req),
    .restore_req    (restore_req),
    .inv_mask       (inv_mask),
    .cwp            (cwp),
    .overflow_trap  (overflow_trap),
    .underflow_trap (underflow_trap)
);

// File: tb/winreg_file_bench.sv
`timescale 1ns/1ps
module winreg_file_bench;

    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, inv_mask = '0;
    logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [4:0]  cwp;
    logic        overflow_trap, underflow_trap;

    always #4 clk = ~clk;

    winreg_file #(.NWIN(NW)) u_winreg_file (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .inv_mask(inv_mask),
        .cwp(cwp), .overflow_trap(overflow_trap), .underflow_trap(underflow_trap)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // Behavioural model: globals, per-window locals and ins; outs are the
    // ins of the window one below.
    logic [31:0] m_glob [8];
    logic [31:0] m_loc  [NW][8];
    logic [31:0] m_ins  [NW][8];
    int          m_cwp;

    function automatic int below(int w);
        return (w + NW - 1) % NW;
    endfunction

    function automatic int above(int w);
        return (w + 1) % NW;
    endfunction

    function automatic logic [31:0] m_rd(int a);
        if (a == 0)  return 32'd0;
        if (a < 8)   return m_glob[a];
        if (a < 16)  return m_ins[below(m_cwp)][a - 8];
        if (a < 24)  return m_loc[m_cwp][a - 16];
        return m_ins[m_cwp][a - 24];
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        if (wr_en && wr_addr != 0 && wr_addr == a) return wr_data;
        return m_rd(int'(a));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        logic sv, rs;
        sv = save_req && !restore_req;
        rs = restore_req && !save_req;
        chk(cur_req, "rd_data_a", rd_data_a, exp_rd(rd_addr_a));
        chk(cur_req, "rd_data_b", rd_data_b, exp_rd(rd_addr_b));
        chk(cur_req, "cwp", 32'(cwp), 32'(m_cwp));
        chk(cur_req, "overflow_trap", 32'(overflow_trap), 32'(sv && inv_mask[below(m_cwp)]));
        chk(cur_req, "underflow_trap", 32'(underflow_trap), 32'(rs && inv_mask[above(m_cwp)]));
    endtask

    task automatic m_update();
        int a;
        a = int'(wr_addr);
        if (wr_en && a != 0) begin
            if (a < 8)       m_glob[a] = wr_data;
            else if (a < 16) m_ins[below(m_cwp)][a - 8] = wr_data;
            else if (a < 24) m_loc[m_cwp][a - 16] = wr_data;
            else             m_ins[m_cwp][a - 24] = wr_data;
        end
        if (save_req && !restore_req && !inv_mask[below(m_cwp)]) m_cwp = below(m_cwp);
        else if (restore_req && !save_req && !inv_mask[above(m_cwp)]) m_cwp = above(m_cwp);
    endtask

    task automatic apply(logic we, int wa, logic [31:0] wd, logic sv, logic rs,
                         logic [31:0] mask, int ra, int rb);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        save_req = sv; restore_req = rs; inv_mask = mask;
        rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        #1;
    endtask

    task automatic tick();
        cmp_all();
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic idle_read(int ra, int rb);
        apply(1'b0, 0, 32'd0, 1'b0, 1'b0, 32'd0, ra, rb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin
                m_loc[w][i] = '0;
                m_ins[w][i] = '0;
            end
        m_cwp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state across every index
        cur_req = "R1";
        for (int a = 0; a < 32; a++) begin
            idle_read(a, 31 - a);
            chk("R1", "reset read", rd_data_a, 32'd0);
            tick();
        end
        chk("R1", "reset cwp", 32'(cwp), 32'd0);

        // R2: index 0 ignores writes, also with a same-cycle read
        cur_req = "R2";
        apply(1'b1, 0, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'd0, 0, 0);
        chk("R2", "read r0 during write", rd_data_a, 32'd0);
        tick();
        idle_read(0, 0);
        chk("R2", "read r0 after write", rd_data_b, 32'd0);
        tick();

        // R3: globals shared across windows
        cur_req = "R3";
        apply(1'b1, 5, 32'h0000_0055, 1'b0, 1'b0, 32'd0, 1, 2); tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, 5, 5); tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, 5, 5); tick();
        idle_read(5, 5);
        chk("R3", "global r5 in window 3", rd_data_a, 32'h55);
        chk("R3", "cwp after two saves", 32'(cwp), 32'd3);
        tick();

        // R4: locals private per window
        cur_req = "R4";
        apply(1'b1, 17, 32'h0000_00A3, 1'b0, 1'b0, 32'd0, 0, 0); tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, 17, 0); tick();
        apply(1'b1, 17, 32'h0000_00B2, 1'b0, 1'b0, 32'd0, 0, 0); tick();
        idle_read(17, 0);
        chk("R4", "local in window 2", rd_data_a, 32'hB2);
        tick();
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'd0, 0, 0); tick();
        idle_read(17, 0);
        chk("R4", "local back in window 3", rd_data_a, 32'hA3);
        tick();

        // R5: outs of w alias ins of w-1
        cur_req = "R5";
        apply(1'b1, 12, 32'h0000_00C3, 1'b0, 1'b0, 32'd0, 0, 0); tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, 0, 0); tick();
        idle_read(28, 0);
        chk("R5", "callee in r28", rd_data_a, 32'hC3);
        tick();
        apply(1'b1, 29, 32'h0000_00D2, 1'b0, 1'b0, 32'd0, 0, 0); tick();
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'd0, 0, 0); tick();
        idle_read(13, 0);
        chk("R5", "caller out r13", rd_data_a, 32'hD2);
        tick();

        // R6: wrap in both directions (cwp is 3)
        cur_req = "R6";
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'd0, 0, 0); tick();
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'd0, 0, 0); tick();
        idle_read(0, 0);
        chk("R6", "restore wraps to 0", 32'(cwp), 32'd0);
        tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, 0, 0); tick();
        idle_read(0, 0);
        chk("R6", "save wraps to NW-1", 32'(cwp), 32'(NW - 1));
        tick();

        // R7: overflow veto (cwp 4, target 3)
        cur_req = "R7";
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'h0000_0008, 0, 0);
        chk("R7", "overflow_trap", 32'(overflow_trap), 32'd1);
        tick();
        idle_read(0, 0);
        chk("R7", "cwp held", 32'(cwp), 32'd4);
        tick();
        apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'hFFFF_FFF7, 0, 0);
        chk("R7", "no trap when target bit clear", 32'(overflow_trap), 32'd0);
        tick();

        // R8: underflow veto (cwp 3, target 4)
        cur_req = "R8";
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'h0000_0010, 0, 0);
        chk("R8", "underflow_trap", 32'(underflow_trap), 32'd1);
        tick();
        idle_read(0, 0);
        chk("R8", "cwp held", 32'(cwp), 32'd3);
        tick();

        // R9: simultaneous requests cancel
        cur_req = "R9";
        apply(1'b0, 0, 32'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 0, 0);
        chk("R9", "no traps", 32'({overflow_trap, underflow_trap}), 32'd0);
        tick();
        idle_read(0, 0);
        chk("R9", "cwp unchanged", 32'(cwp), 32'd3);
        tick();

        // R10: write-first forwarding on both ports
        cur_req = "R10";
        apply(1'b1, 20, 32'h0000_0077, 1'b0, 1'b0, 32'd0, 20, 20);
        chk("R10", "bypass port a", rd_data_a, 32'h77);
        chk("R10", "bypass port b", rd_data_b, 32'h77);
        tick();

        // R11: write during a save goes to the old window
        cur_req = "R11";
        apply(1'b1, 18, 32'h0000_0099, 1'b1, 1'b0, 32'd0, 0, 0); tick();
        idle_read(18, 0);
        chk("R11", "new window local untouched", rd_data_a, 32'd0);
        tick();
        apply(1'b0, 0, 32'd0, 1'b0, 1'b1, 32'd0, 0, 0); tick();
        idle_read(18, 0);
        chk("R11", "old window local written", rd_data_a, 32'h99);
        tick();

        // R11: mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[0] | r[1], int'(r[6:2]), $urandom, r[7] & r[8], r[9] & r[10],
                  $urandom & $urandom & $urandom, int'(r[15:11]), int'(r[20:16]));
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule